// File: doc/BRIEF.md
# 64-bit PCI Single-Phase Write Target Responder

This block is the bus-response side of a PCI target that sits on a 64-bit bus and accepts single-data-phase memory writes. It watches the control lines, command/byte-enable lines and the 64-bit address/data bus. When a memory write arrives that targets its address window, it claims the cycle with medium-speed device select. It inserts a programmable number of target wait states and then completes the one data phase. It hands the written word to a local register port as a one-cycle strobe with data and a byte-lane mask.

The 64-bit acknowledge is settled once, from the 64-bit request as it stood in the address phase. It is then driven in step with device select for the whole claim. A master that drops its 64-bit request together with its frame in the first data clock still gets a full 64-bit transfer. A 32-bit request gets no acknowledge, and only the low lane group is delivered. Every handshake output has its own tri-state enable. After completion the target drives its lines high for one clock and then releases them.

The controller has five states. IDLE waits for an address phase. DECODE is the one dead clock of medium decode. CLAIM holds device select during target wait states. XFER holds target ready until the master is ready. TURN drives the lines high before release. The transitions are:
- IDLE→DECODE on a matching address phase.
- DECODE→XFER when no wait states are configured.
- DECODE→CLAIM when wait states are configured.
- CLAIM→XFER when the wait count is used up.
- XFER→TURN on the completing clock.
- TURN→IDLE unconditionally.

Top module: `pci64_wr_target`

## Requirements
- R1: While reset is asserted and afterwards until a transaction is claimed, all four output enables (device select, target ready, stop, 64-bit acknowledge) are 0 and the write strobe is 0.
- R2: An address phase is a clock where frame_n is sampled 0 after a clock where frame_n and irdy_n were both 1. When cbe_n[3:0] is 4'b0111 (memory write) and ad[31:12] equals the base address bits [31:12] (a 4 KiB window), device select is driven low starting two clocks after the address phase.
- R3: An address outside the window, or any command other than 4'b0111, leaves every output enable at 0 and produces no write strobe.
- R4: Target ready is driven low exactly WAIT_N clocks after device select first goes low (WAIT_N from 0 to 7), and is never low unless device select is low.
- R5: The 64-bit acknowledge is driven low if and only if req64_n was 0 in the address phase. It goes low and high on the same clocks as device select and holds its value while device select is low, whatever req64_n does later.
- R6: The data phase completes only on a clock where irdy_n is sampled 0 while target ready is driven low; extra master wait states hold device select and target ready low.
- R7: The write strobe is high for exactly one clock, the clock after the completing edge. With acknowledge, wr_data is ad[63:0] and wr_mask is ~cbe_n[7:0] from the completing edge. Without acknowledge, wr_data is {32'h0, ad[31:0]} and wr_mask is {4'h0, ~cbe_n[3:0]}.
- R8: In the clock after completion, device select, target ready and acknowledge are driven high with enables 1. On the following clock all enables are 0.
- R9: Stop is never driven low; its enable follows the device select enable.
- R10: A frame_n low on a clock that follows a frame_n-low clock is not an address phase and is never claimed, even with a matching address and command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| frame_n | input | 1 | Frame, active low |
| req64_n | input | 1 | 64-bit request, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| cbe_n | input | 8 | Command (address phase) / byte enables (data phase), active low |
| ad | input | 64 | Address/data bus |
| devsel_o | output | 1 | Device select drive value |
| devsel_oe | output | 1 | Device select drive enable |
| trdy_o | output | 1 | Target ready drive value |
| trdy_oe | output | 1 | Target ready drive enable |
| stop_o | output | 1 | Stop drive value |
| stop_oe | output | 1 | Stop drive enable |
| ack64_o | output | 1 | 64-bit acknowledge drive value |
| ack64_oe | output | 1 | 64-bit acknowledge drive enable |
| wr_strobe | output | 1 | One-clock local write strobe |
| wr_data | output | 64 | Local write data |
| wr_mask | output | 8 | Local byte-lane mask, active high |

## Verification
A controller stuck in or skipping DECODE or CLAIM shows at once as device select or target ready low one clock early or late relative to the address phase. That is visible within WAIT_N+2 clocks. A wrongly latched or recomputed width shows as an acknowledge that disagrees with the address-phase request, or that flips while device select is low. It also shows in the strobe's mask and upper data, in the completing clock or the one after. A controller that misses completion or the turnaround leaves enables on past the clock after the strobe.

// File: rtl/pci64t_pkg.sv
package pci64t_pkg;
    localparam int BUS_W  = 64;
    localparam int LANE_N = BUS_W / 8;
    localparam int HALF_W = BUS_W / 2;
    localparam int ADDR_W = 32;

    localparam logic [3:0] CMD_MEM_WRITE = 4'b0111;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_CLAIM,
        ST_XFER,
        ST_TURN
    } tgt_state_e;
endpackage

// File: rtl/tgt_decode.sv
module tgt_decode
    import pci64t_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h8020_0000,
    parameter int                WIN_BITS  = 12
) (
    input  logic [ADDR_W-WIN_BITS-1:0] addr_hi,
    input  logic [3:0]                 cmd,
    output logic                       hit
);
    localparam int HI_W = ADDR_W - WIN_BITS;
    localparam logic [HI_W-1:0] BASE_HI = BASE_ADDR[ADDR_W-1:WIN_BITS];

    always_comb begin
        hit = (addr_hi == BASE_HI) && (cmd == CMD_MEM_WRITE);
    end
endmodule

// File: rtl/tgt_fsm.sv
module tgt_fsm
    import pci64t_pkg::*;
#(
    parameter int WAIT_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n,
    input  logic irdy_n,
    input  logic req64_n,
    input  logic hit,
    output logic done,
    output logic wide,
    output logic devsel_o,
    output logic devsel_oe,
    output logic trdy_o,
    output logic trdy_oe,
    output logic ack64_o,
    output logic ack64_oe
);
    localparam int CNT_W = (WAIT_N > 1) ? $clog2(WAIT_N) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'((WAIT_N > 0) ? (WAIT_N - 1) : 0);

    tgt_state_e       state, state_nx;
    logic [CNT_W-1:0] wcnt;
    logic             bus_idle_q;
    logic             wide_q;
    logic             addr_phase;

    assign addr_phase = bus_idle_q && !frame_n;
    assign done       = (state == ST_XFER) && !irdy_n;
    assign wide       = wide_q;

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (addr_phase && hit) state_nx = ST_DECODE;
            ST_DECODE: state_nx = (WAIT_N == 0) ? ST_XFER : ST_CLAIM;
            ST_CLAIM:  if (wcnt == '0) state_nx = ST_XFER;
            ST_XFER:   if (!irdy_n) state_nx = ST_TURN;
            ST_TURN:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // wait counter, bus-idle history and width latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt       <= '0;
            bus_idle_q <= 1'b0;
            wide_q     <= 1'b0;
        end else begin
            bus_idle_q <= frame_n && irdy_n;
            if (state == ST_DECODE)
                wcnt <= CNT_LOAD;
            else if (state == ST_CLAIM && wcnt != '0)
                wcnt <= wcnt - 1'b1;
            if (state == ST_IDLE && addr_phase && hit)
                wide_q <= !req64_n;
        end
    end

    // outputs
    always_comb begin
        devsel_o  = 1'b1;
        devsel_oe = 1'b0;
        trdy_o    = 1'b1;
        trdy_oe   = 1'b0;
        ack64_o   = 1'b1;
        ack64_oe  = 1'b0;
        unique case (state)
            ST_IDLE, ST_DECODE: ;
            ST_CLAIM: begin
                devsel_o = 1'b0; devsel_oe = 1'b1;
                trdy_oe  = 1'b1;
                ack64_o  = !wide_q; ack64_oe = 1'b1;
            end
            ST_XFER: begin
                devsel_o = 1'b0; devsel_oe = 1'b1;
                trdy_o   = 1'b0; trdy_oe   = 1'b1;
                ack64_o  = !wide_q; ack64_oe = 1'b1;
            end
            ST_TURN: begin
                devsel_oe = 1'b1;
                trdy_oe   = 1'b1;
                ack64_oe  = 1'b1;
            end
            default: ;
        endcase
    end

    logic dev_on;
    assign dev_on = devsel_oe && !devsel_o;

    // R2
    devsel_medium_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_on) |-> !$past(frame_n, 2));

    // R4
    trdy_inside_devsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trdy_oe && !trdy_o) |-> dev_on);

    // R5
    ack64_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_on && $past(dev_on)) |-> $stable(ack64_o));

    // R5
    ack64_with_devsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack64_oe && !ack64_o) |-> dev_on);

    // R6
    trdy_drop_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trdy_oe && !trdy_o && !irdy_n) |=> (trdy_oe && trdy_o));

    // R8
    release_after_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (devsel_oe && devsel_o) |=> !devsel_oe);
endmodule

// File: rtl/tgt_wcap.sv
module tgt_wcap
    import pci64t_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic              wide,
    input  logic [BUS_W-1:0]  ad,
    input  logic [LANE_N-1:0] cbe_n,
    output logic              wr_strobe,
    output logic [BUS_W-1:0]  wr_data,
    output logic [LANE_N-1:0] wr_mask
);
    localparam int HALF_LANES = LANE_N / 2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_strobe <= 1'b0;
            wr_data   <= '0;
            wr_mask   <= '0;
        end else begin
            wr_strobe <= done;
            if (done) begin
                if (wide) begin
                    wr_data <= ad;
                    wr_mask <= ~cbe_n;
                end else begin
                    wr_data <= {{HALF_W{1'b0}}, ad[HALF_W-1:0]};
                    wr_mask <= {{HALF_LANES{1'b0}}, ~cbe_n[HALF_LANES-1:0]};
                end
            end
        end
    end

    // R7
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> !wr_strobe);
endmodule

// File: rtl/pci64_wr_target.sv
module pci64_wr_target
    import pci64t_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h8020_0000,
    parameter int                WIN_BITS  = 12,
    parameter int                WAIT_N    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              req64_n,
    input  logic              irdy_n,
    input  logic [LANE_N-1:0] cbe_n,
    input  logic [BUS_W-1:0]  ad,
    output logic              devsel_o,
    output logic              devsel_oe,
    output logic              trdy_o,
    output logic              trdy_oe,
    output logic              stop_o,
    output logic              stop_oe,
    output logic              ack64_o,
    output logic              ack64_oe,
    output logic              wr_strobe,
    output logic [BUS_W-1:0]  wr_data,
    output logic [LANE_N-1:0] wr_mask
);
    logic hit, done, wide;

    tgt_decode #(.BASE_ADDR(BASE_ADDR), .WIN_BITS(WIN_BITS)) u_decode (
        .addr_hi (ad[ADDR_W-1:WIN_BITS]),
        .cmd     (cbe_n[3:0]),
        .hit     (hit)
    );

    tgt_fsm #(.WAIT_N(WAIT_N)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_n   (frame_n),
        .irdy_n    (irdy_n),
        .req64_n   (req64_n),
        .hit       (hit),
        .done      (done),
        .wide      (wide),
        .devsel_o  (devsel_o),
        .devsel_oe (devsel_oe),
        .trdy_o    (trdy_o),
        .trdy_oe   (trdy_oe),
        .ack64_o   (ack64_o),
        .ack64_oe  (ack64_oe)
    );

    tgt_wcap u_wcap (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (done),
        .wide      (wide),
        .ad        (ad),
        .cbe_n     (cbe_n),
        .wr_strobe (wr_strobe),
        .wr_data   (wr_data),
        .wr_mask   (wr_mask)
    );

    assign stop_o  = 1'b1;
    assign stop_oe = devsel_oe;
endmodule

// File: tb/test_pci64_wr_target.sv
module test_pci64_wr_target;
    localparam int          CLK_PERIOD = 10;
    localparam int          W          = 2;
    localparam logic [31:0] BASE       = 32'h8020_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1, req64_n = 1'b1, irdy_n = 1'b1;
    logic [7:0]  cbe_n = 8'hFF;
    logic [63:0] ad = '0;
    logic        devsel_o, devsel_oe, trdy_o, trdy_oe, stop_o, stop_oe;
    logic        ack64_o, ack64_oe, wr_strobe;
    logic [63:0] wr_data;
    logic [7:0]  wr_mask;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pci64_wr_target #(.BASE_ADDR(BASE), .WIN_BITS(12), .WAIT_N(W)) i_pci64_wr_target (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .req64_n(req64_n), .irdy_n(irdy_n),
        .cbe_n(cbe_n), .ad(ad), .devsel_o(devsel_o), .devsel_oe(devsel_oe),
        .trdy_o(trdy_o), .trdy_oe(trdy_oe), .stop_o(stop_o), .stop_oe(stop_oe),
        .ack64_o(ack64_o), .ack64_oe(ack64_oe), .wr_strobe(wr_strobe),
        .wr_data(wr_data), .wr_mask(wr_mask)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        frame_n = 1'b1; req64_n = 1'b1; irdy_n = 1'b1; cbe_n = 8'hFF; ad = '0;
        repeat (n) @(negedge clk);
    endtask

    // One single-phase write; d = negedge index where irdy_n is driven low.
    task automatic run_write(input string name, input logic [31:0] addr, input logic [3:0] cmd,
                             input logic rq_addr_n, input logic rq_data_n, input int d,
                             input logic [7:0] be_n, input logic [63:0] data,
                             input logic claim);
        int   c;
        logic wide;
        logic e_doe, e_do, e_to;
        c    = (W + 2 > d + 1) ? W + 2 : d + 1;
        wide = !rq_addr_n;
        frame_n = 1'b0; req64_n = rq_addr_n; irdy_n = 1'b1;
        cbe_n = {4'hF, cmd}; ad = {32'h0, addr};
        @(posedge clk);
        @(negedge clk);
        frame_n = 1'b1; req64_n = rq_data_n; cbe_n = be_n; ad = data;
        for (int j = 0; j <= c + 1; j++) begin
            if (claim) begin
                e_doe = (j >= 1 && j <= c);
                e_do  = !(j >= 1 && j <= c - 1);
                e_to  = !(j >= 1 + W && j <= c - 1);
                chk((j >= c) ? "R8" : "R2", {name, " devsel_oe"}, devsel_oe, e_doe);
                chk("R5", {name, " ack64_oe"}, ack64_oe, e_doe);
                chk("R4", {name, " trdy_oe"}, trdy_oe, e_doe);
                chk("R9", {name, " stop_oe"}, stop_oe, e_doe);
                if (e_doe) begin
                    chk((j == c) ? "R8" : "R2", {name, " devsel_o"}, devsel_o, e_do);
                    chk((j == c) ? "R8" : "R4", {name, " trdy_o"}, trdy_o, e_to);
                    chk("R5", {name, " ack64_o"}, ack64_o, wide ? e_do : 1'b1);
                    chk("R9", {name, " stop_o"}, stop_o, 1'b1);
                end
                chk("R6", {name, " wr_strobe"}, wr_strobe, (j == c));
                if (j == c) begin
                    chk("R7", {name, " wr_data"}, wr_data,
                        wide ? data : {32'h0, data[31:0]});
                    chk("R7", {name, " wr_mask"}, {56'h0, wr_mask},
                        {56'h0, wide ? ~be_n : {4'h0, ~be_n[3:0]}});
                end
            end else begin
                chk("R3", {name, " oe"}, {60'h0, devsel_oe, trdy_oe, ack64_oe, stop_oe}, 64'h0);
                chk("R3", {name, " wr_strobe"}, wr_strobe, 1'b0);
            end
            if (j == d) irdy_n = 1'b0;
            if (j == c) begin irdy_n = 1'b1; req64_n = 1'b1; end
            @(negedge clk);
        end
        idle(2);
    endtask

    // R10: matching address on the second clock of an ongoing frame
    task automatic run_busy_frame();
        frame_n = 1'b0; cbe_n = 8'hF7; ad = 64'h0000_0000_1000_0000;
        @(negedge clk);
        ad = {32'h0, BASE}; irdy_n = 1'b0;
        @(negedge clk);
        frame_n = 1'b1;
        @(negedge clk);
        irdy_n = 1'b1;
        for (int j = 0; j < 6; j++) begin
            chk("R10", "busy devsel_oe", devsel_oe, 1'b0);
            chk("R10", "busy wr_strobe", wr_strobe, 1'b0);
            @(negedge clk);
        end
        idle(2);
    endtask

    task automatic run_reset();
        repeat (3) @(negedge clk);
        chk("R1", "reset oe", {60'h0, devsel_oe, trdy_oe, ack64_oe, stop_oe}, 64'h0);
        chk("R1", "reset wr_strobe", wr_strobe, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "post-reset oe", {60'h0, devsel_oe, trdy_oe, ack64_oe, stop_oe}, 64'h0);
        chk("R1", "post-reset wr_strobe", wr_strobe, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        run_reset();
        // 64-bit, request held
        run_write("w64_hold", BASE + 32'h10, 4'h7, 1'b0, 1'b0, 0, 8'h00,
                  64'hDEAD_BEEF_0123_4567, 1'b1);
        // R5: request dropped with frame in first data clock
        run_write("w64_drop", BASE + 32'h20, 4'h7, 1'b0, 1'b1, 0, 8'h00,
                  64'hCAFE_F00D_89AB_CDEF, 1'b1);
        // R7: 32-bit request, upper lanes suppressed
        run_write("w32", BASE + 32'h30, 4'h7, 1'b1, 1'b1, 0, 8'h00,
                  64'h1111_2222_3333_4444, 1'b1);
        // R5: late request does not acknowledge
        run_write("w32_late_req", BASE + 32'h40, 4'h7, 1'b1, 1'b0, 0, 8'h30,
                  64'h5555_6666_7777_8888, 1'b1);
        // R6: master wait states
        run_write("w64_mwait", BASE + 32'h50, 4'h7, 1'b0, 1'b1, 6, 8'h00,
                  64'h0F0F_0F0F_F0F0_F0F0, 1'b1);
        // R7: partial byte enables
        run_write("w64_bytes", BASE + 32'h60, 4'h7, 1'b0, 1'b1, 1, 8'hA5,
                  64'h0123_4567_89AB_CDEF, 1'b1);
        // R2: top of window
        run_write("w_top", BASE + 32'hFFF, 4'h7, 1'b0, 1'b1, 0, 8'h0F,
                  64'hAAAA_BBBB_CCCC_DDDD, 1'b1);
        // R3: just past the window
        run_write("miss_above", BASE + 32'h1000, 4'h7, 1'b0, 1'b1, 0, 8'h00,
                  64'h1, 1'b0);
        // R3: wrong command (memory read)
        run_write("bad_cmd", BASE + 32'h10, 4'h6, 1'b0, 1'b1, 0, 8'h00,
                  64'h2, 1'b0);
        run_busy_frame();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule